// File: doc/BRIEF.md
# Sprite List Renderer

This block draws the sprites of one frame into a frame buffer. A start pulse begins a pass over a 64-entry sprite table, where each entry is 8 bytes in a 512-byte RAM. For each enabled entry the block reads texels, one byte at a time, from a rectangular window of a 256-texel-wide texture page in graphics memory. Each non-zero texel becomes a pixel write to a 256x256 frame-buffer port, and a one-cycle done pulse closes the pass.

Each sprite has its own position on screen, its own texel origin inside the page, and independent 8 or 16 texel width and height. It can be mirrored horizontally and vertically. A 16-bit base input selects the texture page region. Entries are drawn from entry 0 upward, so where two sprites overlap the later entry's pixels are written last and win in the frame buffer.

Top module: `sprite_list_renderer`

## Requirements
- R1: In reset and between passes, `busy`, `done`, `tex_req` and `px_we` are low. A `start` pulse while idle raises `busy` on the next cycle. `done` is high for exactly one cycle after the last entry is handled, and `busy` is low in that cycle. All pixel writes of the pass come before `done`.
- R2: Entries are handled in ascending index order, 0 to 63, and each sprite's writes are complete before the next entry's writes begin. An overlapping later sprite's write therefore comes after the earlier one.
- R3: Attribute bit 7 enables an entry. An entry with bit 7 clear issues no texel reads and no pixel writes.
- R4: Attribute bit 0 set gives a width of 16 texels, otherwise 8. Attribute bit 1 set gives a height of 16 texels, otherwise 8.
- R5: Attribute bit 2 set places column c at screen x position xpos + (width-1-c). Attribute bit 3 set places row r at ypos + (height-1-r). With a bit clear, the offset is c or r.
- R6: The texel for column c, row r is read at byte address base*256 + ((texX+c) mod 256) + ((texY+r) mod 256)*256, taken modulo 2^24.
- R7: A texel value of 0 produces no pixel write. Any other value is written as `px_color`.
- R8: Screen x and y positions wrap modulo 256.
- R9: At most one texel read is outstanding. A new `tex_req` is only issued after the `tex_valid` for the previous one, and the walk waits for any read latency of one cycle or more.
- R10: A `start` pulse while `busy` is high is ignored. The pass neither restarts nor ends early, and exactly one `done` pulse follows.
- R11: Within a sprite, texels are read and pixels emitted row by row in unmirrored texel order: column 0 to width-1, then the next row.
- R12: The entry layout is: byte 0 is attributes, byte 1 is Y position, byte 2 is X position, byte 4 is texel X origin, byte 5 is texel Y origin. Bytes 3, 6 and 7 have no effect on any output. The table is read with one cycle of latency at address index*8 + byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| gfx_base | input | 16 | Sprite texture base, in 256-byte units |
| tbl_addr | output | 9 | Sprite table read address |
| tbl_data | input | 8 | Sprite table data, one cycle after the address |
| tex_req | output | 1 | One-cycle texel read request |
| tex_addr | output | 24 | Texel byte address, valid with `tex_req` |
| tex_valid | input | 1 | Texel data returned (one pulse per request) |
| tex_data | input | 8 | Texel value, valid with `tex_valid` |
| px_we | output | 1 | Frame-buffer write strobe |
| px_x | output | 8 | Write column |
| px_y | output | 8 | Write row |
| px_color | output | 8 | Written colour index |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
Wrong column or row counters, or a wrong flip decode, show up on the very first texel request or pixel write of the affected sprite. They appear as a wrong `tex_addr` or a wrong `px_x`/`px_y`. A wrong entry index or a slip in field capture misplaces a whole sprite, or starts reads for a disabled one, visible at that entry's first request. An entry counter or pass state that goes wrong shows up as a missing or early `done` pulse, as writes after `done`, or as a second pass when a mid-pass `start` is wrongly accepted.

// File: rtl/spr_pkg.sv
// Package: shared types and constants of the sprite list renderer.
// Assumes 8-bit screen coordinates and 8-byte table entries.
package spr_pkg;

    localparam int COORD_W = 8;    // screen and texel coordinate width
    localparam int SIZE_W  = 4;    // width of in-sprite column/row counters

    // attribute bit positions
    localparam int A_WIDE   = 0;
    localparam int A_TALL   = 1;
    localparam int A_MIRX   = 2;
    localparam int A_MIRY   = 3;
    localparam int A_ENABLE = 7;

    // byte offsets of the used fields inside one entry
    localparam int OFS_ATTR = 0;
    localparam int OFS_YPOS = 1;
    localparam int OFS_XPOS = 2;
    localparam int OFS_TEXX = 4;
    localparam int OFS_TEXY = 5;
    localparam int N_FIELDS = 5;

    typedef struct packed {
        logic               enable;
        logic               mir_y;
        logic               mir_x;
        logic               tall;
        logic               wide;
        logic [COORD_W-1:0] ypos;
        logic [COORD_W-1:0] xpos;
        logic [COORD_W-1:0] texx;
        logic [COORD_W-1:0] texy;
    } spr_desc_t;

    typedef enum logic [1:0] {
        P_IDLE,
        P_LOAD,
        P_DRAW,
        P_NEXT
    } pass_state_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_ISSUE,
        W_WAIT
    } walk_state_t;

    // last index (size-1) of a sprite axis
    function automatic logic [SIZE_W-1:0] axis_last(input logic big);
        return big ? SIZE_W'(15) : SIZE_W'(7);
    endfunction

endpackage

// File: rtl/spr_entry_loader.sv
// Entry loader: reads the five used bytes of one table entry and
// presents them as a decoded descriptor.
// Assumes a table RAM with one cycle of read latency and an entry
// index held stable from load_go until load_done.
module spr_entry_loader
    import spr_pkg::*;
#(
    parameter int ENTRIES     = 64,
    parameter int ENTRY_BYTES = 8,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int OFF_W      = $clog2(ENTRY_BYTES),
    localparam int TBL_AW     = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic [IDX_W-1:0]  load_idx,
    output logic [TBL_AW-1:0] tbl_addr,
    input  logic [7:0]        tbl_data,
    output logic              load_done,
    output spr_desc_t         desc
);

    localparam int FLD_W = $clog2(N_FIELDS);

    logic             issuing;
    logic [FLD_W-1:0] issue_f;
    logic             cap_vld;
    logic [FLD_W-1:0] cap_f;
    logic [7:0]       attr_q, ypos_q, xpos_q, texx_q, texy_q;

    // map a field number to its byte offset inside an entry
    function automatic logic [OFF_W-1:0] field_ofs(input logic [FLD_W-1:0] f);
        case (f)
            FLD_W'(0): return OFF_W'(OFS_ATTR);
            FLD_W'(1): return OFF_W'(OFS_YPOS);
            FLD_W'(2): return OFF_W'(OFS_XPOS);
            FLD_W'(3): return OFF_W'(OFS_TEXX);
            default:   return OFF_W'(OFS_TEXY);
        endcase
    endfunction

    // table address of the field now being requested
    always_comb tbl_addr = {load_idx, field_ofs(issue_f)};

    // issue sequencer and capture of returning bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing   <= 1'b0;
            issue_f   <= '0;
            cap_vld   <= 1'b0;
            cap_f     <= '0;
            load_done <= 1'b0;
            attr_q    <= '0;
            ypos_q    <= '0;
            xpos_q    <= '0;
            texx_q    <= '0;
            texy_q    <= '0;
        end else begin
            load_done <= 1'b0;
            cap_vld   <= issuing;
            cap_f     <= issue_f;
            if (load_go) begin
                issuing <= 1'b1;
                issue_f <= '0;
            end else if (issuing) begin
                if (issue_f == FLD_W'(N_FIELDS - 1)) issuing <= 1'b0;
                else                                 issue_f <= issue_f + 1'b1;
            end
            if (cap_vld) begin
                case (cap_f)
                    FLD_W'(0): attr_q <= tbl_data;
                    FLD_W'(1): ypos_q <= tbl_data;
                    FLD_W'(2): xpos_q <= tbl_data;
                    FLD_W'(3): texx_q <= tbl_data;
                    default:   texy_q <= tbl_data;
                endcase
                if (cap_f == FLD_W'(N_FIELDS - 1)) load_done <= 1'b1;
            end
        end
    end

    // decode the attribute byte into descriptor flags
    always_comb begin
        desc.enable = attr_q[A_ENABLE];
        desc.mir_y  = attr_q[A_MIRY];
        desc.mir_x  = attr_q[A_MIRX];
        desc.tall   = attr_q[A_TALL];
        desc.wide   = attr_q[A_WIDE];
        desc.ypos   = ypos_q;
        desc.xpos   = xpos_q;
        desc.texx   = texx_q;
        desc.texy   = texy_q;
    end

endmodule

// File: rtl/spr_texel_walk.sv
// Texel walker: steps column/row counters across one sprite in
// row-major unmirrored order and issues one texel read per step,
// waiting for each read to return before the next.
// Assumes tex_valid pulses once per request, at least a cycle later.
module spr_texel_walk
    import spr_pkg::*;
#(
    parameter int BASE_W = 16,
    localparam int TEX_AW = BASE_W + COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_go,
    input  logic               wide,
    input  logic               tall,
    input  logic [COORD_W-1:0] texx,
    input  logic [COORD_W-1:0] texy,
    input  logic [BASE_W-1:0]  gfx_base,
    input  logic               tex_valid,
    output logic               tex_req,
    output logic [TEX_AW-1:0]  tex_addr,
    output logic               hit,
    output logic [SIZE_W-1:0]  col,
    output logic [SIZE_W-1:0]  row,
    output logic               walk_end
);

    localparam int PAD_W = TEX_AW - 2 * COORD_W;

    walk_state_t        wst;
    logic [COORD_W-1:0] tcol, trow;
    logic [TEX_AW-1:0]  addr_n;
    logic [SIZE_W-1:0]  col_last, row_last;

    // sizes of the current sprite
    always_comb col_last = axis_last(wide);
    always_comb row_last = axis_last(tall);

    // texel address with per-axis wrap inside the 256-wide page
    always_comb begin
        tcol   = texx + COORD_W'(col);
        trow   = texy + COORD_W'(row);
        addr_n = {gfx_base, {COORD_W{1'b0}}} + {{PAD_W{1'b0}}, trow, tcol};
    end

    // a returning texel for the step in progress
    always_comb hit = (wst == W_WAIT) && tex_valid;

    // walk state, counters and request generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst      <= W_IDLE;
            col      <= '0;
            row      <= '0;
            tex_req  <= 1'b0;
            tex_addr <= '0;
            walk_end <= 1'b0;
        end else begin
            tex_req  <= 1'b0;
            walk_end <= 1'b0;
            case (wst)
                W_IDLE: begin
                    if (walk_go) begin
                        col <= '0;
                        row <= '0;
                        wst <= W_ISSUE;
                    end
                end
                W_ISSUE: begin
                    tex_req  <= 1'b1;
                    tex_addr <= addr_n;
                    wst      <= W_WAIT;
                end
                W_WAIT: begin
                    if (tex_valid) begin
                        if (col == col_last) begin
                            col <= '0;
                            if (row == row_last) begin
                                walk_end <= 1'b1;
                                wst      <= W_IDLE;
                            end else begin
                                row <= row + 1'b1;
                                wst <= W_ISSUE;
                            end
                        end else begin
                            col <= col + 1'b1;
                            wst <= W_ISSUE;
                        end
                    end
                end
                default: wst <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spr_pixel_emit.sv
// Pixel emitter: turns a returned texel into a frame-buffer write,
// applying per-axis mirroring, 256 wrap and zero transparency.
// Assumes col/row still hold the step whose texel is returning.
module spr_pixel_emit
    import spr_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [PIX_W-1:0]   texel,
    input  logic [SIZE_W-1:0]  col,
    input  logic [SIZE_W-1:0]  row,
    input  logic               wide,
    input  logic               tall,
    input  logic               mir_x,
    input  logic               mir_y,
    input  logic [COORD_W-1:0] xpos,
    input  logic [COORD_W-1:0] ypos,
    output logic               px_we,
    output logic [COORD_W-1:0] px_x,
    output logic [COORD_W-1:0] px_y,
    output logic [PIX_W-1:0]   px_color
);

    logic [1:0]         mir;
    logic [1:0]         big;
    logic [SIZE_W-1:0]  step   [2];
    logic [SIZE_W-1:0]  placed [2];
    logic [COORD_W-1:0] origin [2];
    logic [COORD_W-1:0] screen [2];

    // gather per-axis inputs (index 0 is x, index 1 is y)
    always_comb begin
        mir       = {mir_y, mir_x};
        big       = {tall, wide};
        step[0]   = col;
        step[1]   = row;
        origin[0] = xpos;
        origin[1] = ypos;
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        // mirrored or direct offset, then wrapped screen position
        always_comb begin
            placed[a] = mir[a] ? (axis_last(big[a]) - step[a]) : step[a];
            screen[a] = origin[a] + COORD_W'(placed[a]);
        end
    end

    // register the write; zero texels are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_we    <= 1'b0;
            px_x     <= '0;
            px_y     <= '0;
            px_color <= '0;
        end else begin
            px_we <= hit && (texel != '0);
            if (hit) begin
                px_x     <= screen[0];
                px_y     <= screen[1];
                px_color <= texel;
            end
        end
    end

endmodule

// File: rtl/sprite_list_renderer.sv
// Sprite list renderer top: sequences entries 0..ENTRIES-1, loading
// each descriptor and walking enabled sprites, then pulses done.
// Assumes start is a single-cycle pulse; starts while busy are dropped.
module sprite_list_renderer
    import spr_pkg::*;
#(
    parameter int ENTRIES     = 64,
    parameter int ENTRY_BYTES = 8,
    parameter int BASE_W      = 16,
    parameter int PIX_W       = 8,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int TBL_AW     = IDX_W + $clog2(ENTRY_BYTES),
    localparam int TEX_AW     = BASE_W + COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BASE_W-1:0]  gfx_base,
    output logic [TBL_AW-1:0]  tbl_addr,
    input  logic [7:0]         tbl_data,
    output logic               tex_req,
    output logic [TEX_AW-1:0]  tex_addr,
    input  logic               tex_valid,
    input  logic [PIX_W-1:0]   tex_data,
    output logic               px_we,
    output logic [COORD_W-1:0] px_x,
    output logic [COORD_W-1:0] px_y,
    output logic [PIX_W-1:0]   px_color,
    output logic               busy,
    output logic               done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    pass_state_t       pst;
    logic [IDX_W-1:0]  idx;
    logic              load_go, load_done;
    logic              walk_go, walk_end;
    logic              hit;
    logic [SIZE_W-1:0] col, row;
    spr_desc_t         desc;

    spr_entry_loader #(
        .ENTRIES     (ENTRIES),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (load_go),
        .load_idx  (idx),
        .tbl_addr  (tbl_addr),
        .tbl_data  (tbl_data),
        .load_done (load_done),
        .desc      (desc)
    );

    spr_texel_walk #(
        .BASE_W (BASE_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .walk_go   (walk_go),
        .wide      (desc.wide),
        .tall      (desc.tall),
        .texx      (desc.texx),
        .texy      (desc.texy),
        .gfx_base  (gfx_base),
        .tex_valid (tex_valid),
        .tex_req   (tex_req),
        .tex_addr  (tex_addr),
        .hit       (hit),
        .col       (col),
        .row       (row),
        .walk_end  (walk_end)
    );

    spr_pixel_emit #(
        .PIX_W (PIX_W)
    ) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .texel    (tex_data),
        .col      (col),
        .row      (row),
        .wide     (desc.wide),
        .tall     (desc.tall),
        .mir_x    (desc.mir_x),
        .mir_y    (desc.mir_y),
        .xpos     (desc.xpos),
        .ypos     (desc.ypos),
        .px_we    (px_we),
        .px_x     (px_x),
        .px_y     (px_y),
        .px_color (px_color)
    );

    // pass is active whenever the sequencer is not idle
    always_comb busy = (pst != P_IDLE);

    // entry sequencer: load, optionally draw, advance, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst     <= P_IDLE;
            idx     <= '0;
            load_go <= 1'b0;
            walk_go <= 1'b0;
            done    <= 1'b0;
        end else begin
            load_go <= 1'b0;
            walk_go <= 1'b0;
            done    <= 1'b0;
            case (pst)
                P_IDLE: begin
                    if (start) begin
                        idx     <= '0;
                        load_go <= 1'b1;
                        pst     <= P_LOAD;
                    end
                end
                P_LOAD: begin
                    if (load_done) begin
                        if (desc.enable) begin
                            walk_go <= 1'b1;
                            pst     <= P_DRAW;
                        end else begin
                            pst <= P_NEXT;
                        end
                    end
                end
                P_DRAW: begin
                    if (walk_end) pst <= P_NEXT;
                end
                P_NEXT: begin
                    if (idx == LAST_IDX) begin
                        done <= 1'b1;
                        pst  <= P_IDLE;
                    end else begin
                        idx     <= idx + 1'b1;
                        load_go <= 1'b1;
                        pst     <= P_LOAD;
                    end
                end
                default: pst <= P_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spr_render_checker.sv
// Checker: protocol and pass-framing properties of the renderer,
// observed at its ports only. Bound into sprite_list_renderer below.
module spr_render_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       tex_req,
    input logic       tex_valid,
    input logic       px_we,
    input logic [7:0] px_color,
    input logic       busy,
    input logic       done
);

    logic pend;

    // track whether a texel read is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)         pend <= 1'b0;
        else if (tex_req)   pend <= 1'b1;
        else if (tex_valid) pend <= 1'b0;
    end

    // R9: no second request while one is in flight
    p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tex_req |-> !pend);

    // R9: requests only during a pass
    p_req_in_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tex_req |-> busy);

    // R7: transparent texels never reach the frame buffer
    p_no_zero_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        px_we |-> (px_color != 8'd0));

    // R1: done is a single-cycle pulse
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1: done coincides with the end of busy
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1: no activity while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tex_req && !px_we));

    // R1: start while idle launches a pass
    p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10: start while busy does not end the pass early
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

endmodule

bind sprite_list_renderer spr_render_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tex_req   (tex_req),
    .tex_valid (tex_valid),
    .px_we     (px_we),
    .px_color  (px_color),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_sprite_list_renderer.sv
`timescale 1ns/1ps
// Bench: directed corner sprites plus seeded random tables, with
// expected texel addresses and pixel writes built by bench functions.
module sim_sprite_list_renderer;

    localparam int MAXW = 16384;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] gfx_base;
    logic [8:0]  tbl_addr;
    logic [7:0]  tbl_data;
    logic        tex_req;
    logic [23:0] tex_addr;
    logic        tex_valid;
    logic [7:0]  tex_data;
    logic        px_we;
    logic [7:0]  px_x, px_y, px_color;
    logic        busy, done;

    always #2 clk = ~clk;

    sprite_list_renderer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .gfx_base(gfx_base),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .tex_req(tex_req), .tex_addr(tex_addr),
        .tex_valid(tex_valid), .tex_data(tex_data),
        .px_we(px_we), .px_x(px_x), .px_y(px_y), .px_color(px_color),
        .busy(busy), .done(done)
    );

    logic [7:0]  tbl_mem [0:511];
    logic [23:0] exp_a   [0:MAXW-1];
    logic [23:0] exp_p   [0:MAXW-1];
    int exp_an, exp_pn, ai, wi, done_cnt;
    int checks = 0, errors = 0;
    bit monitor_on = 0;

    // table RAM with one cycle of read latency (R12)
    always @(posedge clk) tbl_data <= tbl_mem[tbl_addr];

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // graphics memory content: a hash with frequent zero texels
    function automatic logic [7:0] tex_fn(input logic [23:0] a);
        logic [31:0] h;
        h = {8'd0, a} * 32'h9E3779B1;
        h = h ^ (h >> 15);
        if (h[10:8] == 3'd0) return 8'd0;
        return h[7:0];
    endfunction

    // expected reads and writes for the whole table (R2..R8, R11)
    task automatic build_expect();
        exp_an = 0;
        exp_pn = 0;
        for (int e = 0; e < 64; e++) begin
            logic [7:0] at, yp, xp, tx, ty;
            int w, h;
            at = tbl_mem[e*8 + 0];
            yp = tbl_mem[e*8 + 1];
            xp = tbl_mem[e*8 + 2];
            tx = tbl_mem[e*8 + 4];
            ty = tbl_mem[e*8 + 5];
            if (at[7]) begin
                w = at[0] ? 16 : 8;
                h = at[1] ? 16 : 8;
                for (int r = 0; r < h; r++) begin
                    for (int c = 0; c < w; c++) begin
                        int ad, sx, sy;
                        logic [7:0] v;
                        ad = (int'(gfx_base) * 256 + ((int'(tx) + c) % 256)
                              + ((int'(ty) + r) % 256) * 256) % (1 << 24);
                        exp_a[exp_an] = 24'(ad);
                        exp_an++;
                        v  = tex_fn(24'(ad));
                        sx = (int'(xp) + (at[2] ? (w - 1 - c) : c)) % 256;
                        sy = (int'(yp) + (at[3] ? (h - 1 - r) : r)) % 256;
                        if (v != 8'd0) begin
                            exp_p[exp_pn] = {8'(sx), 8'(sy), v};
                            exp_pn++;
                        end
                    end
                end
            end
        end
    endtask

    // texel responder and output monitor, away from the active edge
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [23:0] paddr = '0;
        tex_valid = 1'b0;
        tex_data  = 8'd0;
        forever begin
            @(negedge clk);
            tex_valid = 1'b0;
            if (monitor_on) begin
                if (pend) begin
                    if (cnt == 0) begin
                        tex_valid = 1'b1;
                        tex_data  = tex_fn(paddr);
                        pend      = 0;
                    end else begin
                        cnt--;
                    end
                end
                if (tex_req) begin
                    check(!pend, "R9 request while read outstanding", 1, 0);
                    if (ai < exp_an)
                        check(tex_addr == exp_a[ai], "R6/R11 texel address", tex_addr, exp_a[ai]);
                    else
                        check(0, "R3 unexpected texel read", tex_addr, 0);
                    ai++;
                    pend  = 1;
                    paddr = tex_addr;
                    cnt   = int'($urandom_range(0, 3));
                end
                if (px_we) begin
                    if (wi < exp_pn)
                        check({px_x, px_y, px_color} == exp_p[wi],
                              "R2/R5/R7/R8 pixel write {x,y,c}", {px_x, px_y, px_color}, exp_p[wi]);
                    else
                        check(0, "R3/R7 unexpected pixel write", {px_x, px_y, px_color}, 0);
                    wi++;
                end
                if (done) begin
                    done_cnt++;
                    check(wi == exp_pn, "R1 writes complete at done", wi, exp_pn);
                    check(!busy, "R1 busy low with done", busy, 0);
                end
            end
        end
    end

    // run one pass; optionally pulse start again mid-pass (R10)
    task automatic run_pass(input bit inject);
        int n;
        build_expect();
        ai = 0;
        wi = 0;
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R1 busy after start", busy, 1);
        if (inject) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (done_cnt == 0 && n < 40000) begin
            @(negedge clk);
            n++;
        end
        if (done_cnt == 0) check(0, "R1 watchdog expired", n, 0);
        repeat (4) @(negedge clk);
        check(done_cnt == 1, "R1/R10 one done per pass", done_cnt, 1);
        check(ai == exp_an, "R9/R11 texel read count", ai, exp_an);
        check(wi == exp_pn, "R2 pixel write count", wi, exp_pn);
        check(!busy, "R10 pass not restarted", busy, 0);
    endtask

    task automatic clear_table();
        for (int i = 0; i < 512; i++) tbl_mem[i] = 8'($urandom) & 8'h7F;
    endtask

    task automatic put_entry(input int e, input logic [7:0] at, input logic [7:0] y,
                             input logic [7:0] x, input logic [7:0] tx, input logic [7:0] ty);
        tbl_mem[e*8 + 0] = at;
        tbl_mem[e*8 + 1] = y;
        tbl_mem[e*8 + 2] = x;
        tbl_mem[e*8 + 3] = 8'($urandom);   // R12: unused bytes carry junk
        tbl_mem[e*8 + 4] = tx;
        tbl_mem[e*8 + 5] = ty;
        tbl_mem[e*8 + 6] = 8'($urandom);
        tbl_mem[e*8 + 7] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5A17E));
        rst_n    = 1'b0;
        start    = 1'b0;
        gfx_base = 16'h0000;
        for (int i = 0; i < 512; i++) tbl_mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({busy, done, tex_req, px_we} == 4'b0, "R1 reset outputs", {busy, done, tex_req, px_we}, 0);
        monitor_on = 1;

        // R3: every entry disabled, junk elsewhere
        clear_table();
        run_pass(0);

        // R5/R8/R6/R12: 8x8 x-mirror at screen and texel wrap edges
        clear_table();
        gfx_base = 16'h1234;
        put_entry(5, 8'h84, 8'hFC, 8'hFA, 8'hFE, 8'hFD);
        run_pass(0);

        // R4/R5/R2: 16x16 y-mirror, then overlapping both-mirror 16x8, then 8x16
        clear_table();
        gfx_base = 16'hFFFF;
        put_entry(2,  8'h8B, 8'h40, 8'h50, 8'h10, 8'hF8);
        put_entry(3,  8'h8D, 8'h44, 8'h54, 8'h20, 8'h30);
        put_entry(63, 8'h82, 8'hF8, 8'h00, 8'hF0, 8'h00);
        run_pass(0);

        // random tables, some with a start pulse mid-pass (R10)
        for (int p = 0; p < 3; p++) begin
            clear_table();
            gfx_base = 16'($urandom);
            for (int k = 0; k < 10; k++)
                put_entry(int'($urandom_range(0, 63)), 8'h80 | (8'($urandom) & 8'h0F),
                          8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            run_pass(p != 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule